// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block runs next to a simple 32-bit CPU pipeline and carries out the hardware part of taking and leaving an exception. The pipeline raises one of four entry requests: data abort, prefetch abort, software interrupt, or an unrecognised instruction. Each request comes with the address of the instruction concerned. On entry the block does three things. It produces a write of the return address into the link register of the target mode. It copies the live status word into that mode's saved-status slot. It changes the mode field, sets the IRQ-disable bit and redirects fetch to a fixed vector. A one-cycle flush pulse tells the pipeline to drop the instructions it has already fetched.

An unrecognised instruction is not trapped at once. It is first offered to a coprocessor port. While an accepting coprocessor reports busy, the offer is held, and the core stalls on it, until the coprocessor becomes ready or an interrupt is pending. The undefined-instruction trap is taken only when no coprocessor accepts the instruction. An exception return request redirects fetch to a supplied address and reloads the status word from the saved slot of the current mode.

The status word is kept inside the block. Mode is in bits [4:0], the IRQ-disable bit is at bit 7 and the condition flags are in bits [31:28]. The pipeline updates the flags through a small write port. The register file, address translation and decoding belong to other blocks.

Top module: `exc_entry_seq`

## Requirements
- R1: A data abort writes instruction address + 8 to the link register of mode 10111, sets the mode field to 10111 and redirects fetch to VEC_BASE + 0x10.
- R2: A prefetch abort writes instruction address + 4 to the link register of mode 10111, sets the mode field to 10111 and redirects fetch to VEC_BASE + 0x0C.
- R3: A software interrupt writes instruction address + 4 to the link register of mode 10011, sets the mode field to 10011 and redirects fetch to VEC_BASE + 0x08.
- R4: On every entry, the saved-status slot of the target mode receives the status word from before the entry. Bit 7 (IRQ disable) is set, and every bit other than [4:0] and bit 7 keeps its value.
- R5: Requests sampled in the same cycle are served in this order: data abort, prefetch abort, unrecognised instruction, software interrupt, return. The others are dropped.
- R6: An entry or a return takes effect at the clock edge that samples it. lr_we (entries only), redirect and flush are high for exactly the following cycle. Every request sampled while flush is high is ignored.
- R7: An unrecognised instruction raises cp_offer in the following cycle. If cp_accept is low in an offer cycle, the offer drops at the next edge and the trap is taken at that same edge: link register of mode 11011 gets address + 4, the mode becomes 11011 and fetch is redirected to VEC_BASE + 0x04.
- R8: In an offer cycle with cp_accept high, the offer stays up while cp_busy is high and irq_pending is low. It drops with no trap when cp_busy is low or irq_pending is high. Requests sampled while the offer is up are ignored.
- R9: A return redirects fetch to ret_pc, pulses flush and writes no link register. It loads the status word from the saved slot of the current mode (10111, 10011 or 11011). In any other mode it leaves the status word unchanged.
- R10: flags_we writes flags_in into status bits [31:28] in any cycle in which no entry or return takes effect.
- R11: After reset the status word is 0x00000093 (mode 10011, IRQ disabled), every saved-status slot holds 0x00000010, and lr_we, redirect, flush and cp_offer are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_addr | input | AW | Address of the instruction tied to the current request |
| req_dabt | input | 1 | Data abort request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Unrecognised instruction request |
| req_swi | input | 1 | Software interrupt request |
| ret_req | input | 1 | Exception return with status restore |
| ret_pc | input | AW | Target address of the return |
| flags_we | input | 1 | Condition flag write enable |
| flags_in | input | 4 | New condition flags for bits [31:28] |
| irq_pending | input | 1 | Interrupt pending; abandons a busy coprocessor wait |
| cp_accept | input | 1 | A coprocessor claims the offered instruction |
| cp_busy | input | 1 | The claiming coprocessor is not yet ready |
| cp_offer | output | 1 | Instruction is being offered to coprocessors (core stalls) |
| lr_we | output | 1 | Link register write strobe |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_data | output | AW | Return address to write |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_addr | output | AW | New fetch address |
| flush | output | 1 | Discard already fetched instructions |
| psr | output | 32 | Current status word |

## Verification
Most internal faults in this block show at the ports one cycle after the edge that samples the request. An arbitration or offset error corrupts lr_mode, lr_data or redirect_addr in that cycle. A slip in the saved-status banks stays hidden until a later return, when psr reloads a wrong value, possibly many cycles after the entry that stored it. An error in the offer state machine shows as cp_offer held too long or dropped too early, or as a trap appearing or missing at the edge after an offer cycle. The stimulus therefore chains entries and returns across modes, so that stored slots are read back through psr.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   typedef enum logic [2:0] {
      K_NONE = 3'd0,
      K_DABT = 3'd1,
      K_PABT = 3'd2,
      K_UND  = 3'd3,
      K_SWI  = 3'd4,
      K_RET  = 3'd5
   } exc_kind_e;

   localparam logic [4:0] MODE_USR = 5'b10000;
   localparam logic [4:0] MODE_SVC = 5'b10011;
   localparam logic [4:0] MODE_ABT = 5'b10111;
   localparam logic [4:0] MODE_UND = 5'b11011;

   localparam int PSR_W   = 32;
   localparam int MODE_W  = 5;
   localparam int FLAGS_W = 4;
   localparam int N_BANKS = 3;

   // mode that an entry of the given kind switches to
   function automatic logic [MODE_W-1:0] target_mode(exc_kind_e k);
      case (k)
         K_DABT, K_PABT: return MODE_ABT;
         K_UND:          return MODE_UND;
         default:        return MODE_SVC;
      endcase
   endfunction

   // distance from the instruction address to the stored return address
   function automatic logic [3:0] link_offset(exc_kind_e k);
      return (k == K_DABT) ? 4'd8 : 4'd4;
   endfunction

   // vector offset above the vector base
   function automatic logic [7:0] vector_offset(exc_kind_e k);
      case (k)
         K_DABT:  return 8'h10;
         K_PABT:  return 8'h0C;
         K_SWI:   return 8'h08;
         K_UND:   return 8'h04;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic bank_valid(logic [MODE_W-1:0] m);
      return (m == MODE_ABT) || (m == MODE_SVC) || (m == MODE_UND);
   endfunction

   function automatic logic [1:0] bank_index(logic [MODE_W-1:0] m);
      case (m)
         MODE_SVC: return 2'd1;
         MODE_UND: return 2'd2;
         default:  return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/exc_req_arbiter.sv
module exc_req_arbiter
   import exc_seq_pkg::*;
(
   input  logic      enable,
   input  logic      req_dabt,
   input  logic      req_pabt,
   input  logic      req_und,
   input  logic      req_swi,
   input  logic      req_ret,
   output exc_kind_e kind
);

   always_comb begin
      kind = K_NONE;
      if (enable) begin
         if (req_dabt)      kind = K_DABT;
         else if (req_pabt) kind = K_PABT;
         else if (req_und)  kind = K_UND;
         else if (req_swi)  kind = K_SWI;
         else if (req_ret)  kind = K_RET;
      end
   end

   always_comb begin
      a_idle_when_blocked_r6: assert (enable || kind == K_NONE)
         else $error("arbiter granted while blocked");
   end

endmodule

// File: rtl/exc_cp_handshake.sv
module exc_cp_handshake #(
   parameter int AW         = 32,
   parameter bit HAS_COPROC = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] ins_addr,
   input  logic          cp_accept,
   input  logic          cp_busy,
   input  logic          irq_pending,
   output logic          offer,
   output logic          trap,
   output logic [AW-1:0] trap_addr
);

   generate
      if (HAS_COPROC) begin : g_offer
         logic          offer_q;
         logic [AW-1:0] addr_q;
         logic          release_w;

         assign release_w = offer_q && (!cp_accept || !cp_busy || irq_pending);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               offer_q <= 1'b0;
               addr_q  <= '0;
            end else if (start) begin
               offer_q <= 1'b1;
               addr_q  <= ins_addr;
            end else if (release_w) begin
               offer_q <= 1'b0;
            end
         end

         assign offer     = offer_q;
         assign trap      = offer_q && !cp_accept;
         assign trap_addr = addr_q;

         p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (offer_q && cp_accept && cp_busy && !irq_pending) |=> offer_q)
            else $error("offer dropped during busy wait");

         p_ready_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (offer_q && cp_accept && (!cp_busy || irq_pending)) |=> !offer_q)
            else $error("offer kept after ready or interrupt");

         p_reject_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (offer_q && !cp_accept) |=> !offer_q)
            else $error("offer kept after rejection");

         p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
            start |-> !offer_q)
            else $error("new offer while one is pending");
      end else begin : g_direct
         logic unused_cp;
         assign unused_cp = ^{clk, rst_n, cp_accept, cp_busy, irq_pending};
         assign offer     = 1'b0;
         assign trap      = start;
         assign trap_addr = ins_addr;
      end
   endgenerate

endmodule

// File: rtl/exc_psr_bank.sv
module exc_psr_bank
   import exc_seq_pkg::*;
#(
   parameter int I_BIT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enter,
   input  logic [MODE_W-1:0]  enter_mode,
   input  logic               restore,
   input  logic               flags_we,
   input  logic [FLAGS_W-1:0] flags_in,
   output logic [PSR_W-1:0]   psr
);

   localparam logic [PSR_W-1:0] I_MASK     = PSR_W'(1) << I_BIT;
   localparam logic [PSR_W-1:0] RESET_PSR  = I_MASK | PSR_W'(MODE_SVC);
   localparam logic [PSR_W-1:0] SPSR_RESET = PSR_W'(MODE_USR);
   localparam logic [PSR_W-1:0] KEEP_MASK  = ~(I_MASK | PSR_W'({MODE_W{1'b1}}));

   logic [PSR_W-1:0] psr_q;
   logic [PSR_W-1:0] psr_d;
   logic [PSR_W-1:0] spsr_q [N_BANKS];
   logic             cur_ok;
   logic [1:0]       cur_idx;
   logic [1:0]       ent_idx;

   assign cur_ok  = bank_valid(psr_q[MODE_W-1:0]);
   assign cur_idx = bank_index(psr_q[MODE_W-1:0]);
   assign ent_idx = bank_index(enter_mode);

   always_comb begin
      psr_d = psr_q;
      if (enter) begin
         psr_d[MODE_W-1:0] = enter_mode;
         psr_d[I_BIT]      = 1'b1;
      end else if (restore) begin
         if (cur_ok) psr_d = spsr_q[cur_idx];
      end else if (flags_we) begin
         psr_d[PSR_W-1 -: FLAGS_W] = flags_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) psr_q <= RESET_PSR;
      else        psr_q <= psr_d;
   end

   generate
      for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               spsr_q[b] <= SPSR_RESET;
            else if (enter && ent_idx == 2'(b))
               spsr_q[b] <= psr_q;
         end
      end
   endgenerate

   assign psr = psr_q;

   p_save_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> spsr_q[$past(ent_idx)] == $past(psr_q))
      else $error("saved-status slot not loaded on entry");

   p_keep_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> ((psr_q & KEEP_MASK) == ($past(psr_q) & KEEP_MASK)) && psr_q[I_BIT])
      else $error("status fields disturbed on entry");

   p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (restore && !enter && cur_ok) |=> psr_q == $past(spsr_q[cur_idx]))
      else $error("status not restored on return");

   p_unbanked_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (restore && !enter && !cur_ok) |=> $stable(psr_q))
      else $error("status changed on return from unbanked mode");

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_seq_pkg::*;
#(
   parameter int            AW         = 32,
   parameter logic [AW-1:0] VEC_BASE   = '0,
   parameter bit            HAS_COPROC = 1'b1,
   parameter int            I_BIT      = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ins_addr,
   input  logic          req_dabt,
   input  logic          req_pabt,
   input  logic          req_und,
   input  logic          req_swi,
   input  logic          ret_req,
   input  logic [AW-1:0] ret_pc,
   input  logic          flags_we,
   input  logic [3:0]    flags_in,
   input  logic          irq_pending,
   input  logic          cp_accept,
   input  logic          cp_busy,
   output logic          cp_offer,
   output logic          lr_we,
   output logic [4:0]    lr_mode,
   output logic [AW-1:0] lr_data,
   output logic          redirect,
   output logic [AW-1:0] redirect_addr,
   output logic          flush,
   output logic [31:0]   psr
);

   generate
      if (AW < 8 || AW > 64) begin : g_bad_aw
         $error("exc_entry_seq: AW must be within 8..64");
      end
      if (I_BIT < MODE_W || I_BIT >= PSR_W - FLAGS_W) begin : g_bad_ibit
         $error("exc_entry_seq: I_BIT must lie between mode field and flags");
      end
   endgenerate

   exc_kind_e     arb_kind;
   exc_kind_e     eff_kind;
   logic          blocked;
   logic          und_start;
   logic          und_trap;
   logic [AW-1:0] trap_addr;
   logic [AW-1:0] eff_addr;
   logic          do_enter;
   logic          do_ret;
   logic [4:0]    ent_mode;

   logic          lr_we_q;
   logic [4:0]    lr_mode_q;
   logic [AW-1:0] lr_data_q;
   logic          redir_q;
   logic [AW-1:0] redir_addr_q;
   logic          flush_q;

   assign blocked = flush_q | cp_offer;

   exc_req_arbiter u_arb (
      .enable   (!blocked),
      .req_dabt (req_dabt),
      .req_pabt (req_pabt),
      .req_und  (req_und),
      .req_swi  (req_swi),
      .req_ret  (ret_req),
      .kind     (arb_kind)
   );

   assign und_start = (arb_kind == K_UND);

   exc_cp_handshake #(
      .AW         (AW),
      .HAS_COPROC (HAS_COPROC)
   ) u_cp (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (und_start),
      .ins_addr    (ins_addr),
      .cp_accept   (cp_accept),
      .cp_busy     (cp_busy),
      .irq_pending (irq_pending),
      .offer       (cp_offer),
      .trap        (und_trap),
      .trap_addr   (trap_addr)
   );

   always_comb begin
      if (und_trap)             eff_kind = K_UND;
      else if (arb_kind == K_UND) eff_kind = K_NONE;
      else                      eff_kind = arb_kind;
   end

   assign eff_addr = und_trap ? trap_addr : ins_addr;
   assign do_ret   = (eff_kind == K_RET);
   assign do_enter = (eff_kind != K_NONE) && !do_ret;
   assign ent_mode = target_mode(eff_kind);

   exc_psr_bank #(
      .I_BIT (I_BIT)
   ) u_psr (
      .clk        (clk),
      .rst_n      (rst_n),
      .enter      (do_enter),
      .enter_mode (ent_mode),
      .restore    (do_ret),
      .flags_we   (flags_we),
      .flags_in   (flags_in),
      .psr        (psr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_we_q      <= 1'b0;
         lr_mode_q    <= '0;
         lr_data_q    <= '0;
         redir_q      <= 1'b0;
         redir_addr_q <= '0;
         flush_q      <= 1'b0;
      end else begin
         lr_we_q <= do_enter;
         redir_q <= do_enter | do_ret;
         flush_q <= do_enter | do_ret;
         if (do_enter) begin
            lr_mode_q    <= ent_mode;
            lr_data_q    <= eff_addr + AW'(link_offset(eff_kind));
            redir_addr_q <= VEC_BASE + AW'(vector_offset(eff_kind));
         end else if (do_ret) begin
            redir_addr_q <= ret_pc;
         end
      end
   end

   assign lr_we         = lr_we_q;
   assign lr_mode       = lr_mode_q;
   assign lr_data       = lr_data_q;
   assign redirect      = redir_q;
   assign redirect_addr = redir_addr_q;
   assign flush         = flush_q;

   p_flush_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !flush)
      else $error("flush longer than one cycle");

   p_flush_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !redirect)
      else $error("request taken during flush");

   p_dabt_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_dabt && !flush && !cp_offer) |=>
         (lr_we && lr_mode == MODE_ABT && lr_data == $past(ins_addr) + AW'(8)
          && redirect && redirect_addr == VEC_BASE + AW'(16)))
      else $error("data abort entry wrong");

   p_entry_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we |-> (redirect && flush && psr[I_BIT] && psr[4:0] == lr_mode))
      else $error("entry outputs inconsistent with status");

   p_offer_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cp_offer) |-> !redirect)
      else $error("redirect while offer starts");

endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;

   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ins_addr = '0;
   logic          req_dabt = 0, req_pabt = 0, req_und = 0, req_swi = 0, ret_req = 0;
   logic [AW-1:0] ret_pc = '0;
   logic          flags_we = 0;
   logic [3:0]    flags_in = '0;
   logic          irq_pending = 0, cp_accept = 0, cp_busy = 0;
   logic          cp_offer, lr_we, redirect, flush;
   logic [4:0]    lr_mode;
   logic [AW-1:0] lr_data, redirect_addr;
   logic [31:0]   psr;

   always #5 clk = ~clk;

   exc_entry_seq uut (
      .clk(clk), .rst_n(rst_n), .ins_addr(ins_addr),
      .req_dabt(req_dabt), .req_pabt(req_pabt), .req_und(req_und), .req_swi(req_swi),
      .ret_req(ret_req), .ret_pc(ret_pc), .flags_we(flags_we), .flags_in(flags_in),
      .irq_pending(irq_pending), .cp_accept(cp_accept), .cp_busy(cp_busy),
      .cp_offer(cp_offer), .lr_we(lr_we), .lr_mode(lr_mode), .lr_data(lr_data),
      .redirect(redirect), .redirect_addr(redirect_addr), .flush(flush), .psr(psr)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // reference state
   logic [31:0]   m_psr;
   logic [31:0]   m_spsr [3];
   bit            m_flush, m_offer;
   logic [AW-1:0] m_oaddr;
   bit            e_lr_we, e_redir, e_flush;
   logic [4:0]    e_lr_mode;
   logic [AW-1:0] e_lr_data, e_raddr;
   string         cur_tag;
   string         dtag = "";

   function automatic int slot_of(logic [4:0] m);
      if (m == 5'b10111) return 0;
      if (m == 5'b10011) return 1;
      if (m == 5'b11011) return 2;
      return -1;
   endfunction

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_psr = 32'h0000_0093;
      for (int i = 0; i < 3; i++) m_spsr[i] = 32'h0000_0010;
      m_flush = 0; m_offer = 0; m_oaddr = '0;
      e_lr_we = 0; e_redir = 0; e_flush = 0; e_lr_mode = '0; e_lr_data = '0; e_raddr = '0;
   endtask

   task automatic model_step();
      int k;
      logic [AW-1:0] a;
      logic [4:0] md;
      int sl;
      string t;
      k = 0; a = ins_addr; t = "R6";
      e_lr_we = 0; e_redir = 0; e_flush = 0;
      if (m_offer) begin
         if (!cp_accept) begin k = 3; a = m_oaddr; m_offer = 0; t = "R7"; end
         else begin
            if (!cp_busy || irq_pending) m_offer = 0;
            t = "R8";
         end
      end else if (!m_flush) begin
         if (req_dabt) k = 1;
         else if (req_pabt) k = 2;
         else if (req_und) begin m_offer = 1; m_oaddr = ins_addr; t = "R7"; end
         else if (req_swi) k = 4;
         else if (ret_req) k = 5;
      end
      if (k >= 1 && k <= 4) begin
         md = (k == 1 || k == 2) ? 5'b10111 : (k == 3) ? 5'b11011 : 5'b10011;
         m_spsr[slot_of(md)] = m_psr;
         m_psr[4:0] = md;
         m_psr[7] = 1'b1;
         e_lr_we = 1; e_lr_mode = md;
         e_lr_data = a + ((k == 1) ? 32'd8 : 32'd4);
         e_redir = 1; e_flush = 1;
         e_raddr = (k == 1) ? 32'h10 : (k == 2) ? 32'h0C : (k == 3) ? 32'h04 : 32'h08;
         t = (k == 1) ? "R1" : (k == 2) ? "R2" : (k == 3) ? "R7" : "R3";
      end else if (k == 5) begin
         sl = slot_of(m_psr[4:0]);
         if (sl >= 0) m_psr = m_spsr[sl];
         e_redir = 1; e_flush = 1; e_raddr = ret_pc;
         t = "R9";
      end else if (flags_we) begin
         m_psr[31:28] = flags_in;
         if (t == "R6") t = "R10";
      end
      m_flush = e_flush;
      cur_tag = (dtag != "") ? dtag : t;
   endtask

   task automatic compare();
      check(lr_we == e_lr_we, cur_tag, "lr_we", 64'(lr_we), 64'(e_lr_we));
      check(redirect == e_redir, cur_tag, "redirect", 64'(redirect), 64'(e_redir));
      check(flush == e_flush, cur_tag, "flush", 64'(flush), 64'(e_flush));
      check(cp_offer == m_offer, cur_tag, "cp_offer", 64'(cp_offer), 64'(m_offer));
      check(psr == m_psr, (e_lr_we && dtag == "") ? "R4" : cur_tag, "psr", 64'(psr), 64'(m_psr));
      if (e_lr_we) begin
         check(lr_mode == e_lr_mode, cur_tag, "lr_mode", 64'(lr_mode), 64'(e_lr_mode));
         check(lr_data == e_lr_data, cur_tag, "lr_data", 64'(lr_data), 64'(e_lr_data));
      end
      if (e_redir)
         check(redirect_addr == e_raddr, cur_tag, "redirect_addr", 64'(redirect_addr), 64'(e_raddr));
   endtask

   // inputs are set at a negedge; this samples the next edge and checks at the following negedge
   task automatic tick();
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic clr();
      req_dabt = 0; req_pabt = 0; req_und = 0; req_swi = 0; ret_req = 0;
      flags_we = 0; irq_pending = 0; cp_accept = 0; cp_busy = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      // R11 reset values
      check(psr == 32'h93, "R11", "psr reset", 64'(psr), 64'h93);
      check(!lr_we && !redirect && !flush && !cp_offer, "R11", "strobes reset",
            64'({lr_we, redirect, flush, cp_offer}), 64'h0);
      rst_n = 1;
      @(negedge clk);

      // R11 saved slot reset value read back by return from SVC
      dtag = "R11"; clr(); ret_req = 1; ret_pc = 32'h0000_4000; tick();
      dtag = ""; clr(); tick();
      // R10 flags in user mode
      flags_we = 1; flags_in = 4'hA; tick(); clr(); tick();
      // R3 software interrupt from user mode
      req_swi = 1; ins_addr = 32'h100; tick(); clr(); tick();
      // R9 return back to user
      ret_req = 1; ret_pc = 32'h104; tick(); clr(); tick();
      // R9 return in user mode leaves status
      dtag = "R9"; ret_req = 1; ret_pc = 32'h200; tick(); dtag = ""; clr(); tick();
      // R2 then R1
      req_pabt = 1; ins_addr = 32'h2000; tick(); clr(); tick();
      req_dabt = 1; ins_addr = 32'h3000; tick(); clr(); tick();
      // R5 all requests at once
      dtag = "R5"; req_dabt = 1; req_pabt = 1; req_und = 1; req_swi = 1; ret_req = 1;
      ins_addr = 32'h5000; tick(); dtag = ""; clr(); tick();
      dtag = "R5"; req_pabt = 1; req_swi = 1; ins_addr = 32'h5100; tick(); dtag = ""; clr(); tick();
      // R6 request during flush is ignored
      req_swi = 1; ins_addr = 32'h6000; tick();
      dtag = "R6"; clr(); req_dabt = 1; ins_addr = 32'h6100; tick(); dtag = ""; clr(); tick();
      // R7 offer rejected -> trap
      req_und = 1; ins_addr = 32'h7000; tick();
      clr(); cp_accept = 0; tick(); clr(); tick();
      // R8 busy wait then ready; requests ignored meanwhile
      req_und = 1; ins_addr = 32'h8000; tick();
      dtag = "R8"; clr(); cp_accept = 1; cp_busy = 1; req_dabt = 1; tick(); tick(); tick();
      clr(); cp_accept = 1; cp_busy = 0; tick(); dtag = ""; clr(); tick();
      // R8 busy wait abandoned by interrupt
      req_und = 1; ins_addr = 32'h9000; tick();
      dtag = "R8"; clr(); cp_accept = 1; cp_busy = 1; tick();
      irq_pending = 1; tick(); dtag = ""; clr(); tick();
      // R10 flags blocked by simultaneous entry
      dtag = "R10"; req_swi = 1; ins_addr = 32'hA000; flags_we = 1; flags_in = 4'h5; tick();
      dtag = ""; clr(); tick();

      // random mix
      for (int n = 0; n < 4000; n++) begin
         clr();
         req_dabt    = ($urandom_range(0, 99) < 6);
         req_pabt    = ($urandom_range(0, 99) < 6);
         req_und     = ($urandom_range(0, 99) < 8);
         req_swi     = ($urandom_range(0, 99) < 8);
         ret_req     = ($urandom_range(0, 99) < 10);
         flags_we    = ($urandom_range(0, 99) < 20);
         flags_in    = 4'($urandom());
         cp_accept   = ($urandom_range(0, 99) < 70);
         cp_busy     = ($urandom_range(0, 99) < 50);
         irq_pending = ($urandom_range(0, 99) < 10);
         ins_addr    = $urandom() & 32'hFFFF_FFFC;
         ret_pc      = $urandom() & 32'hFFFF_FFFC;
         tick();
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule